// File: doc/BRIEF.md
# Two-Tier Maskable Interrupt Priority Resolver

This block chooses which of 22 maskable interrupt sources, numbered 4 through 25, is presented to the processor. Every source has a pending line and an individual enable line. Software gives each source a 2-bit priority level through six byte-wide control registers. The registers sit on a plain address, write-data and write-strobe bus, and reads return data in the same cycle.

Arbitration runs in two tiers. The pending and enabled source with the highest programmed level wins. When several sources share that level, the one with the larger source number wins. A master enable gates the result. Software sets and clears the master enable with separate one-cycle pulses, and it drops by itself when the processor acknowledges an interrupt. The winner is recomputed combinationally in every cycle. Pending flags belong to the requesting logic and are never cleared here.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, every control register reads 0x00, every level is 0, `mst_en_o` is 0 and `irq_valid_o` is 0.
- R2: Register address 0xFF0+k (k = 0..5) holds the levels of sources 4k+4 to 4k+7. Source 4k+4 is in bits 1:0, 4k+5 in bits 3:2, 4k+6 in bits 5:4 and 4k+7 in bits 7:6. A written byte reads back unchanged.
- R3: At 0xFF5, bits 7:4 read as 0 and ignore writes. Addresses outside 0xFF0..0xFF5 read 0x00 and ignore writes.
- R4: Level codes are 00 = level 0 (lowest), 01 = level 1, 10 = level 2 and 11 = level 3 (highest). A source at a higher level beats any source at a lower level, whatever the source numbers.
- R5: Among requesting sources at the same highest level, the larger source number wins.
- R6: A source takes part only when both its pending bit and its enable bit are 1. Bit i of `pend_i` and `src_en_i` belongs to source i+4.
- R7: While `mst_en_o` is 0, `irq_valid_o` is 0. Whenever `irq_valid_o` is 0, `irq_id_o` is 0.
- R8: A pulse on `mst_set_i` sets `mst_en_o` at the next edge. A pulse on `mst_clr_i` clears it, and the clear wins when both are high. With no control high, `mst_en_o` holds.
- R9: `ack_i` clears `mst_en_o` at the next edge and wins over `mst_set_i`. During the acknowledge cycle, `irq_id_o` shows the winning source.
- R10: `irq_valid_o` and `irq_id_o` follow `pend_i`, `src_en_i` and the stored levels in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 12 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| pend_i | input | 22 | Pending flags, bit i is source i+4 |
| src_en_i | input | 22 | Per-source enables, bit i is source i+4 |
| mst_set_i | input | 1 | Sets the master enable |
| mst_clr_i | input | 1 | Clears the master enable |
| ack_i | input | 1 | Interrupt acknowledge, clears the master enable |
| irq_valid_o | output | 1 | An interrupt is presented |
| irq_id_o | output | 5 | Winning source number (4..25), 0 when not valid |
| mst_en_o | output | 1 | Current master enable |

## Verification
Some rules are checked by the assertions in every cycle:
- the gating by the master enable and the zero identifier when nothing is valid;
- that the presented source really is pending and enabled, and lies in range;
- the next-state rules for set, clear and acknowledge;
- the zero read data in the spare bits of the last register and outside the register window.

Other behaviour only the bench's scenarios can show, because it needs a model of the stored levels:
- that the winner sits at the highest level present, and that ties go to the larger source number;
- that each field lies where the register map says.

The bench compares these against its own level model over directed cases and randomized register and request patterns.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_arb_pkg::*;
#(
    parameter int          NUM_SRC   = 22,
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 8,
    parameter int unsigned BASE_ADDR = 32'h0000_0FF0
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic                     we_i,
    output logic [DATA_W-1:0]        rdata_o,
    output lvl_t [NUM_SRC-1:0]       lvl_o
);
    localparam int SLOTS   = DATA_W / LVL_W;
    localparam int NUM_REG = (NUM_SRC + SLOTS - 1) / SLOTS;

    typedef struct packed {
        lvl_t [NUM_SRC-1:0] lvl;
    } regs_t;

    regs_t             st_d, st_q;
    logic [ADDR_W-1:0] off;
    logic              hit;

    always_comb begin
        off     = addr_i - ADDR_W'(BASE_ADDR);
        hit     = (addr_i >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(NUM_REG));
        st_d    = st_q;
        rdata_o = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (hit && (off == ADDR_W'(s / SLOTS))) begin
                rdata_o[(s % SLOTS)*LVL_W +: LVL_W] = st_q.lvl[s];
                if (we_i) begin
                    st_d.lvl[s] = wdata_i[(s % SLOTS)*LVL_W +: LVL_W];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;
endmodule

// File: rtl/irq_level_select.sv
module irq_level_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 22,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  lvl_t [NUM_SRC-1:0] lvl_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);
    lvl_t best_lvl;

    // Ascending scan; ">=" lets a later (higher-numbered) source take a tie.
    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        best_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (!found_o || (lvl_i[i] >= best_lvl))) begin
                found_o  = 1'b1;
                idx_o    = IDX_W'(i);
                best_lvl = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_master_ctl.sv
module irq_master_ctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    input  logic ack_i,
    output logic en_o
);
    typedef struct packed {
        logic en;
    } mst_t;

    mst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_i || clr_i) begin
            st_d.en = 1'b0;
        end else if (set_i) begin
            st_d.en = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int          NUM_SRC   = 22,
    parameter int          FIRST_SRC = 4,
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 8,
    parameter int unsigned BASE_ADDR = 32'h0000_0FF0,
    parameter int          ID_W      = $clog2(FIRST_SRC + NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    input  logic               reg_we_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               mst_set_i,
    input  logic               mst_clr_i,
    input  logic               ack_i,
    output logic               irq_valid_o,
    output logic [ID_W-1:0]    irq_id_o,
    output logic               mst_en_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    lvl_t [NUM_SRC-1:0] lvl;
    logic [NUM_SRC-1:0] req;
    logic               found;
    logic [IDX_W-1:0]   win_idx;

    irq_prio_regs #(
        .NUM_SRC  (NUM_SRC),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .addr_i (reg_addr_i),
        .wdata_i(reg_wdata_i),
        .we_i   (reg_we_i),
        .rdata_o(reg_rdata_o),
        .lvl_o  (lvl)
    );

    assign req = pend_i & src_en_i;

    irq_level_select #(
        .NUM_SRC(NUM_SRC),
        .IDX_W  (IDX_W)
    ) u_sel (
        .req_i  (req),
        .lvl_i  (lvl),
        .found_o(found),
        .idx_o  (win_idx)
    );

    irq_master_ctl u_mst (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (mst_set_i),
        .clr_i (mst_clr_i),
        .ack_i (ack_i),
        .en_o  (mst_en_o)
    );

    always_comb begin
        irq_valid_o = found && mst_en_o;
        irq_id_o    = irq_valid_o ? (ID_W'(win_idx) + ID_W'(FIRST_SRC)) : '0;
    end
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
    parameter int          NUM_SRC   = 22,
    parameter int          FIRST_SRC = 4,
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 8,
    parameter int unsigned BASE_ADDR = 32'h0000_0FF0,
    parameter int          ID_W      = $clog2(FIRST_SRC + NUM_SRC)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic [NUM_SRC-1:0] pend_i,
    input logic [NUM_SRC-1:0] src_en_i,
    input logic               mst_set_i,
    input logic               mst_clr_i,
    input logic               ack_i,
    input logic               irq_valid_o,
    input logic [ID_W-1:0]    irq_id_o,
    input logic               mst_en_o
);
    localparam int SLOTS     = DATA_W / 2;
    localparam int NUM_REG   = (NUM_SRC + SLOTS - 1) / SLOTS;
    localparam int SPARE     = (NUM_REG * SLOTS - NUM_SRC) * 2;
    localparam int LAST_ADDR = int'(BASE_ADDR) + NUM_REG - 1;

    logic [NUM_SRC-1:0] req_sh;
    assign req_sh = (pend_i & src_en_i) >> (irq_id_o - ID_W'(FIRST_SRC));

    // R7
    valid_needs_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mst_en_o |-> !irq_valid_o);
    // R7
    idle_id_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_valid_o |-> (irq_id_o == '0));
    // R6
    winner_requests_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_valid_o |-> req_sh[0]);
    // R6
    winner_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_valid_o |-> ((irq_id_o >= ID_W'(FIRST_SRC)) && (irq_id_o < ID_W'(FIRST_SRC + NUM_SRC))));
    // R8
    clear_drops_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mst_clr_i |=> !mst_en_o);
    // R8
    set_raises_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mst_set_i && !mst_clr_i && !ack_i) |=> mst_en_o);
    // R8
    master_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mst_set_i && !mst_clr_i && !ack_i) |=> $stable(mst_en_o));
    // R9
    ack_drops_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i |=> !mst_en_o);
    // R3
    spare_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == ADDR_W'(LAST_ADDR)) |-> ((reg_rdata_o >> (DATA_W - SPARE)) == '0));
    // R3
    outside_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((reg_addr_i < ADDR_W'(BASE_ADDR)) || (reg_addr_i > ADDR_W'(LAST_ADDR))) |-> (reg_rdata_o == '0));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
    .NUM_SRC  (NUM_SRC),
    .FIRST_SRC(FIRST_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE_ADDR(BASE_ADDR),
    .ID_W     (ID_W)
) u_chk (.*);

// File: tb/test_irq_level_arbiter.sv
module test_irq_level_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic [21:0] pend = '0;
    logic [21:0] src_en = '0;
    logic        mst_set = 1'b0;
    logic        mst_clr = 1'b0;
    logic        ack = 1'b0;
    logic        irq_valid;
    logic [4:0]  irq_id;
    logic        mst_en;

    int n_chk = 0;
    int n_fail = 0;
    int lvl_m [22];
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_level_arbiter i_irq_level_arbiter (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_we_i(reg_we), .reg_rdata_o(reg_rdata),
        .pend_i(pend), .src_en_i(src_en),
        .mst_set_i(mst_set), .mst_clr_i(mst_clr), .ack_i(ack),
        .irq_valid_o(irq_valid), .irq_id_o(irq_id), .mst_en_o(mst_en)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_addr = 12'(a); reg_wdata = 8'(d); reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (a >= 'hFF0 && a <= 'hFF5) begin
            for (int k = 0; k < 4; k++) begin
                int s = (a - 'hFF0) * 4 + k;
                if (s < 22) lvl_m[s] = (d >> (2 * k)) & 3;
            end
        end
    endtask

    task automatic rd_chk(string tag, int a, int exp);
        reg_addr = 12'(a);
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic pulse(bit s, bit c, bit k);
        @(negedge clk);
        mst_set = s; mst_clr = c; ack = k;
        @(negedge clk);
        mst_set = 1'b0; mst_clr = 1'b0; ack = 1'b0;
    endtask

    function automatic int exp_id();
        int best = -1;
        int bl = -1;
        for (int i = 0; i < 22; i++) begin
            if (pend[i] && src_en[i] && lvl_m[i] >= bl) begin
                best = i; bl = lvl_m[i];
            end
        end
        return best;
    endfunction

    task automatic arb_chk(string tag);
        int b;
        #1;
        b = exp_id();
        if (mst_en && b >= 0) begin
            chk({tag, " valid"}, int'(irq_valid), 1);
            chk({tag, " id"}, int'(irq_id), b + 4);
        end else begin
            chk({tag, " valid"}, int'(irq_valid), 0);
            chk({tag, " id"}, int'(irq_id), 0);
        end
    endtask

    task automatic t_reset();
        for (int a = 'hFF0; a <= 'hFF5; a++) rd_chk("R1 reset reg", a, 0);
        chk("R1 reset master", int'(mst_en), 0);
        chk("R1 reset valid", int'(irq_valid), 0);
    endtask

    task automatic t_regmap();
        wr('hFF0, 'hC0);
        rd_chk("R2 readback ff0", 'hFF0, 'hC0);
        wr('hFF3, 'h1B);
        rd_chk("R2 readback ff3", 'hFF3, 'h1B);
        pulse(1, 0, 0);
        chk("R8 set", int'(mst_en), 1);
        src_en = '1;
        pend = 22'b1001;
        arb_chk("R2 src7 top field");
        chk("R2 src7 wins", int'(irq_id), 7);
        wr('hFF0, 'h03);
        arb_chk("R2 src4 low field");
        chk("R2 src4 wins", int'(irq_id), 4);
    endtask

    task automatic t_last_reg();
        wr('hFF5, 'hFF);
        rd_chk("R3 spare bits", 'hFF5, 'h0F);
        wr('hFF6, 'h5A);
        rd_chk("R3 above window", 'hFF6, 0);
        wr('hFEF, 'hA5);
        rd_chk("R3 below window", 'hFEF, 0);
        for (int a = 'hFF0; a <= 'hFF5; a++) begin
            int e = 0;
            for (int k = 0; k < 4; k++) begin
                int s = (a - 'hFF0) * 4 + k;
                if (s < 22) e |= lvl_m[s] << (2 * k);
            end
            rd_chk("R3 window intact", a, e);
        end
    endtask

    task automatic t_levels();
        for (int a = 'hFF0; a <= 'hFF5; a++) wr(a, 0);
        src_en = '1;
        // source 5 at level 2 (code 10) against source 25 at level 1 (code 01)
        wr('hFF0, 'h08);
        wr('hFF5, 'h04);
        pend = (22'b1 << 1) | (22'b1 << 21);
        arb_chk("R4 level beats number");
        chk("R4 src5", int'(irq_id), 5);
        wr('hFF5, 'h0C);
        arb_chk("R4 level3 code 11");
        chk("R4 src25", int'(irq_id), 25);
    endtask

    task automatic t_tie();
        for (int a = 'hFF0; a <= 'hFF5; a++) wr(a, 0);
        pend = (22'b1 << 0) | (22'b1 << 6) | (22'b1 << 21);
        src_en = '1;
        arb_chk("R5 tie level0");
        chk("R5 src25", int'(irq_id), 25);
        wr('hFF1, 'hAA);
        pend = 22'b1111_0000;
        arb_chk("R5 tie level2");
        chk("R5 src11", int'(irq_id), 11);
    endtask

    task automatic t_enable();
        pend = 22'b1111_0000;
        src_en = ~(22'b1 << 7);
        arb_chk("R6 disabled top");
        chk("R6 src10", int'(irq_id), 10);
        src_en = '0;
        arb_chk("R6 none enabled");
        src_en = '1;
        pend = '0;
        arb_chk("R6 none pending");
    endtask

    task automatic t_master();
        pend = 22'b1; src_en = '1;
        pulse(0, 1, 0);
        chk("R8 clear", int'(mst_en), 0);
        arb_chk("R7 gated");
        pulse(1, 1, 0);
        chk("R8 clear beats set", int'(mst_en), 0);
        pulse(1, 0, 0);
        repeat (3) @(negedge clk);
        chk("R8 holds", int'(mst_en), 1);
        arb_chk("R10 live");
        pend = 22'b100;
        arb_chk("R10 follows pend");
    endtask

    task automatic t_ack();
        int b;
        pend = 22'b1010; src_en = '1;
        @(negedge clk);
        ack = 1'b1;
        #1;
        b = exp_id();
        chk("R9 id during ack", int'(irq_id), b + 4);
        @(negedge clk);
        ack = 1'b0;
        chk("R9 ack clears", int'(mst_en), 0);
        chk("R9 valid drops", int'(irq_valid), 0);
        pulse(1, 0, 1);
        chk("R9 ack beats set", int'(mst_en), 0);
    endtask

    task automatic t_random();
        pulse(1, 0, 0);
        for (int n = 0; n < 300; n++) begin
            if (n % 3 == 0) wr('hFF0 + int'($urandom_range(0, 5)), int'($urandom_range(0, 255)));
            @(negedge clk);
            pend = 22'($urandom);
            src_en = 22'($urandom);
            arb_chk("R4 R5 R6 random");
        end
    endtask

    initial begin
        for (int i = 0; i < 22; i++) lvl_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_last_reg();
        t_levels();
        t_tie();
        t_enable();
        t_master();
        t_ack();
        t_random();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule